// File: doc/BRIEF.md
# Launch-on-Capture Scan Self-Test Sequencer

This block paces a scan-based logic self-test. After a start request it repeats the same cycle for every pattern. First it holds scan enable high for as many cycles as the chains are long. During those cycles the next pattern moves into the chains and the previous response moves out into the signature compactor. Then it drops scan enable for a capture window. In stuck-at mode the window is one capture clock. In transition mode it is two back-to-back functional clocks. In that case the core's answer to the first clock becomes the launch pattern for the second, so the sequencer never supplies a second pattern of its own.

The shift counter and the pattern counter are outputs, because the pattern-modifying logic next to the pseudo-random generator decodes them. The compactor enable is also an output. It stays low while the first pattern loads, since nothing useful sits in the chains then. After the last capture, one more full shift pass unloads the final response. Done then rises, and the signature stays in the compactor for comparison.

States: IDLE (waiting), SHIFT (load and unload), CAP1 (first capture), CAP2 (second functional clock, transition mode only), UNLOAD (final unload pass), DONE (holding). Transitions: IDLE or DONE to SHIFT on an accepted start. SHIFT to CAP1 on the last shift cycle. CAP1 to CAP2 in transition mode. The last capture cycle goes to SHIFT, or to UNLOAD after the final pattern, and it also steps the pattern counter. UNLOAD to DONE on its last shift cycle.

Top module: `lbist_seq_ctrl`

## Requirements
- R1: While reset is asserted and after its release, with no start, scan_en_o, cap1_o, cap2_o, misr_en_o and done_o are 0, and both counters read 0.
- R2: A start_i sampled high in IDLE or DONE makes the next cycle a shift cycle: scan_en_o=1, shift_cnt_o=0, pat_cnt_o=0.
- R3: Every shift phase (each pattern load and the final unload) holds scan_en_o high for exactly CHAIN_LEN consecutive cycles, with shift_cnt_o reading 0,1,...,CHAIN_LEN-1 in those cycles. shift_cnt_o is 0 whenever scan_en_o is low.
- R4: In stuck-at mode (trans_mode_i=0 when start is accepted), each capture window is exactly one cycle with scan_en_o=0 and cap1_o=1.
- R5: In transition mode (trans_mode_i=1 when start is accepted), each capture window is exactly two consecutive cycles with scan_en_o=0. cap1_o=1 in the first and cap2_o=1 in the second, and the two strobes are never high together.
- R6: pat_cnt_o holds the index (from 0) of the pattern being loaded and captured. It increments at the clock edge that ends the last capture cycle of that pattern, and reaches PATTERNS after the final capture.
- R7: misr_en_o is 1 in every shift cycle except those loading pattern 0, and 0 in every non-shift cycle.
- R8: After the last pattern's capture, one unload pass of CHAIN_LEN cycles runs with misr_en_o=1. done_o then rises. In DONE, scan_en_o and both strobes stay 0, pat_cnt_o=PATTERNS and shift_cnt_o=0 until the next start. From start to done this takes PATTERNS*(CHAIN_LEN+w)+CHAIN_LEN cycles, where w is the window width.
- R9: trans_mode_i is sampled only when a start is accepted. Changing it during a run has no effect on window widths.
- R10: start_i pulses while a run is in progress are ignored. Counters, window widths and total run length are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, accepted in IDLE or DONE |
| trans_mode_i | input | 1 | 1 = two-clock launch-on-capture window, 0 = single capture |
| scan_en_o | output | 1 | Scan enable to all chains |
| cap1_o | output | 1 | First capture strobe |
| cap2_o | output | 1 | Second functional clock strobe (transition mode) |
| misr_en_o | output | 1 | Signature compactor enable |
| shift_cnt_o | output | $clog2(CHAIN_LEN) | Shift position within the current pass |
| pat_cnt_o | output | $clog2(PATTERNS+1) | Index of the current pattern |
| done_o | output | 1 | Test finished, signature final |

## Verification
The sequencer runs four times: a plain stuck-at run, a plain transition run, and one run in each mode with mode flips and spurious start pulses injected midway. Comparing low-pulse widths and strobe order between the plain runs tells the one-clock window apart from the two-clock window. The disturbed runs show whether the mode is latched at start and whether busy starts are dropped, since either fault would change a pulse width or the total length. Each shift run's length, counter sequence and compactor-enable count are checked. These checks separate the silent first load from the compacting loads and the final unload.

// File: rtl/bist_pkg.sv
package bist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_CAP1,
        ST_CAP2,
        ST_UNLOAD,
        ST_DONE
    } bist_state_e;

endpackage

// File: rtl/bist_cnt.sv
module bist_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_o <= '0;
        end else if (inc_i) begin
            cnt_o <= cnt_o + W'(1);
        end
    end

endmodule

// File: rtl/bist_fsm.sv
module bist_fsm
    import bist_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic trans_mode_i,
    input  logic shift_last_i,
    input  logic pat_last_i,
    input  logic first_pat_i,
    output logic scan_en_o,
    output logic cap1_o,
    output logic cap2_o,
    output logic misr_en_o,
    output logic done_o,
    output logic pat_clr_o,
    output logic pat_inc_o
);

    bist_state_e state_q, state_d;
    logic        mode_q;
    logic        accept;

    assign accept    = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
    assign pat_clr_o = accept;

    // state register (mode is latched only on an accepted start)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                mode_q <= trans_mode_i;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SHIFT;
            ST_SHIFT:  if (shift_last_i) state_d = ST_CAP1;
            ST_CAP1: begin
                if (mode_q)          state_d = ST_CAP2;
                else if (pat_last_i) state_d = ST_UNLOAD;
                else                 state_d = ST_SHIFT;
            end
            ST_CAP2:   state_d = pat_last_i ? ST_UNLOAD : ST_SHIFT;
            ST_UNLOAD: if (shift_last_i) state_d = ST_DONE;
            ST_DONE:   if (accept) state_d = ST_SHIFT;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs (Moore, decoded from state)
    always_comb begin
        scan_en_o = 1'b0;
        cap1_o    = 1'b0;
        cap2_o    = 1'b0;
        misr_en_o = 1'b0;
        done_o    = 1'b0;
        pat_inc_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SHIFT: begin
                scan_en_o = 1'b1;
                misr_en_o = !first_pat_i;
            end
            ST_CAP1: begin
                cap1_o    = 1'b1;
                pat_inc_o = !mode_q;
            end
            ST_CAP2: begin
                cap2_o    = 1'b1;
                pat_inc_o = 1'b1;
            end
            ST_UNLOAD: begin
                scan_en_o = 1'b1;
                misr_en_o = 1'b1;
            end
            ST_DONE:  done_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/lbist_seq_ctrl.sv
module lbist_seq_ctrl #(
    parameter int CHAIN_LEN = 8,
    parameter int PATTERNS  = 5,
    localparam int SC_W     = (CHAIN_LEN > 2) ? $clog2(CHAIN_LEN) : 1,
    localparam int PC_W     = $clog2(PATTERNS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            trans_mode_i,
    output logic            scan_en_o,
    output logic            cap1_o,
    output logic            cap2_o,
    output logic            misr_en_o,
    output logic [SC_W-1:0] shift_cnt_o,
    output logic [PC_W-1:0] pat_cnt_o,
    output logic            done_o
);

    logic shift_last, pat_last, first_pat;
    logic pat_clr, pat_inc;
    logic shift_clr;

    assign shift_last = (shift_cnt_o == SC_W'(CHAIN_LEN - 1));
    assign pat_last   = (pat_cnt_o == PC_W'(PATTERNS - 1));
    assign first_pat  = (pat_cnt_o == '0);
    assign shift_clr  = !scan_en_o || shift_last;

    bist_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .trans_mode_i (trans_mode_i),
        .shift_last_i (shift_last),
        .pat_last_i   (pat_last),
        .first_pat_i  (first_pat),
        .scan_en_o    (scan_en_o),
        .cap1_o       (cap1_o),
        .cap2_o       (cap2_o),
        .misr_en_o    (misr_en_o),
        .done_o       (done_o),
        .pat_clr_o    (pat_clr),
        .pat_inc_o    (pat_inc)
    );

    bist_cnt #(.W(SC_W)) u_shift_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (shift_clr),
        .inc_i (scan_en_o),
        .cnt_o (shift_cnt_o)
    );

    bist_cnt #(.W(PC_W)) u_pat_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (pat_clr),
        .inc_i (pat_inc),
        .cnt_o (pat_cnt_o)
    );

endmodule

// File: rtl/lbist_seq_chk.sv
module lbist_seq_chk #(
    parameter int CHAIN_LEN = 8,
    parameter int PATTERNS  = 5,
    localparam int SC_W     = (CHAIN_LEN > 2) ? $clog2(CHAIN_LEN) : 1,
    localparam int PC_W     = $clog2(PATTERNS + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            scan_en_o,
    input logic            cap1_o,
    input logic            cap2_o,
    input logic            misr_en_o,
    input logic [SC_W-1:0] shift_cnt_o,
    input logic [PC_W-1:0] pat_cnt_o,
    input logic            done_o
);

    localparam logic [SC_W-1:0] LAST = SC_W'(CHAIN_LEN - 1);

    p_shift_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en_o && shift_cnt_o != LAST) |=>
        (scan_en_o && shift_cnt_o == $past(shift_cnt_o) + SC_W'(1)));

    p_shift_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_en_o && shift_cnt_o == LAST) |=> (!scan_en_o && shift_cnt_o == '0));

    p_cap_no_scan_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap1_o || cap2_o) |-> (!scan_en_o && !(cap1_o && cap2_o)));

    p_cap2_after_cap1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap2_o |-> $past(cap1_o));

    p_cap2_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap2_o |=> (scan_en_o || (!cap1_o && !cap2_o)));

    p_pat_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pat_cnt_o <= PC_W'(PATTERNS));

    p_misr_in_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        misr_en_o |-> scan_en_o);

    p_done_final_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (pat_cnt_o == PC_W'(PATTERNS) && $past(misr_en_o)));

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!scan_en_o && !cap1_o && !cap2_o && shift_cnt_o == '0));

endmodule

bind lbist_seq_ctrl lbist_seq_chk #(
    .CHAIN_LEN (CHAIN_LEN),
    .PATTERNS  (PATTERNS)
) u_chk (.*);

// File: tb/tb_lbist_seq_ctrl.sv
`timescale 1ns/1ps
module tb_lbist_seq_ctrl;

    localparam int L    = 8;
    localparam int P    = 5;
    localparam int SC_W = $clog2(L);
    localparam int PC_W = $clog2(P + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            mode = 1'b0;
    logic            scan_en, cap1, cap2, misr_en, done;
    logic [SC_W-1:0] shift_cnt;
    logic [PC_W-1:0] pat_cnt;

    always #2.5 clk = ~clk;

    lbist_seq_ctrl #(.CHAIN_LEN(L), .PATTERNS(P)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .trans_mode_i (mode),
        .scan_en_o    (scan_en),
        .cap1_o       (cap1),
        .cap2_o       (cap2),
        .misr_en_o    (misr_en),
        .shift_cnt_o  (shift_cnt),
        .pat_cnt_o    (pat_cnt),
        .done_o       (done)
    );

    typedef struct { int len; int misr; } hi_t;
    typedef struct { int width; int pat; } lo_t;
    hi_t hq[$];
    lo_t lq[$];

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: measures scan-enable runs and compares against the scoreboard
    int hrun = 0, hmisr = 0, lrun = 0, lpat = 0;
    bit hbad = 0, lbad = 0, seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (scan_en) begin
                if (lrun > 0) begin
                    if (lq.size() == 0) begin
                        chk(0, "R6 unexpected capture window", lrun, 0);
                    end else begin
                        lo_t e;
                        e = lq.pop_front();
                        chk(lrun == e.width && !lbad, (e.width == 1) ? "R4 window" : "R5 window",
                            lrun, e.width);
                        chk(lpat == e.pat, "R6 pattern index", lpat, e.pat);
                    end
                    lrun = 0;
                    lbad = 0;
                end
                if (int'(shift_cnt) != hrun) hbad = 1;
                if (misr_en) hmisr++;
                hrun++;
                seen = 1;
            end else begin
                if (hrun > 0) begin
                    if (hq.size() == 0) begin
                        chk(0, "R3 unexpected shift run", hrun, 0);
                    end else begin
                        hi_t e;
                        e = hq.pop_front();
                        chk(hrun == e.len && !hbad, "R3 shift run", hrun, e.len);
                        chk(hmisr == e.misr, "R7 compactor cycles", hmisr, e.misr);
                    end
                    hrun = 0;
                    hmisr = 0;
                    hbad = 0;
                end
                if (misr_en) lbad = 1;
                if (!done && seen) begin
                    if (lrun == 0) begin
                        lpat = int'(pat_cnt);
                        if (!cap1 || cap2) lbad = 1;
                    end else if (lrun == 1) begin
                        if (cap1 || !cap2) lbad = 1;
                    end else begin
                        lbad = 1;
                    end
                    lrun++;
                end
            end
        end
    end

    // driver: pushes expected items, starts a run, optionally disturbs it
    task automatic run_test(input bit m, input bit disturb);
        int w;
        int cyc;
        w = m ? 2 : 1;
        for (int i = 0; i < P; i++) lq.push_back('{w, i});
        for (int k = 0; k <= P; k++) hq.push_back('{L, (k == 0) ? 0 : L});
        @(negedge clk);
        mode  = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(scan_en && shift_cnt == 0 && pat_cnt == 0, "R2 start",
            int'(scan_en), 1);
        cyc = 1;
        while (!done && cyc < 10000) begin
            @(negedge clk);
            if (!done) cyc++;
            if (disturb) begin
                if (cyc == 3)  start = 1'b1;
                if (cyc == 4)  start = 1'b0;
                if (cyc == 5)  mode = ~m;
                if (cyc == 12) start = 1'b1;
                if (cyc == 13) start = 1'b0;
            end
        end
        chk(cyc == P * (L + w) + L, disturb ? "R9 R10 run length" : "R8 run length",
            cyc, P * (L + w) + L);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(done && !scan_en && !cap1 && !cap2 && pat_cnt == PC_W'(P) && shift_cnt == 0,
                "R8 done hold", int'(pat_cnt), P);
        end
        chk(lq.size() == 0 && hq.size() == 0, "R6 scoreboard drained",
            lq.size() + hq.size(), 0);
        lq.delete();
        hq.delete();
        mode = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!scan_en && !cap1 && !cap2 && !misr_en && !done && shift_cnt == 0 && pat_cnt == 0,
            "R1 in reset", int'(scan_en), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!scan_en && !cap1 && !cap2 && !misr_en && !done && shift_cnt == 0 && pat_cnt == 0,
            "R1 idle", int'(done), 0);
        run_test(1'b0, 1'b0);
        run_test(1'b1, 1'b0);
        run_test(1'b1, 1'b1);
        run_test(1'b0, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule